// File: doc/BRIEF.md
# Per-Bank Open Page Tracker

This block sits in front of a DRAM command scheduler and classifies each incoming read or write by the state of the row buffer it targets. For every chip select and logical bank it holds one open-row record, made of an open flag, the row number and an idle counter. A request to an open bank whose row matches is a hit and can go straight to a column command. A request to an open bank with another row is a row conflict, which needs a precharge and then an activate. A request to a closed bank needs an activate only.

Page policy is chosen per chip select. Under closed-page policy every column command leaves with its auto-precharge address bit set, and the bank is recorded as closed once the access is done. Under open-page policy the bit is clear and the row stays open. An open row is dropped in three cases: its idle time reaches a programmable limit, which raises a single-bank precharge request; a refresh request arrives, which raises a precharge-all before refresh is granted; or another row is requested in that bank. The DRAM timing parameters and the data path belong to other blocks.

Top module: `page_tracker`

## Requirements
- R1: For a valid request, `dec_class` is 2'b00 (hit) when the addressed bank is open with the same row, 2'b10 (conflict) when it is open with another row, and 2'b01 (activate) when it is closed. The decision is combinational in the request cycle.
- R2: When `cfg_closed_page[cs]` is 1, the request's `cmd_col` has bit 10 set, and the bank is closed after the access, so a repeat of the same row is classified as activate.
- R3: When `cfg_closed_page[cs]` is 0, `cmd_col` bit 10 is clear and the bank stays open on the requested row, so a repeat of the same row is a hit.
- R4: The page policy of each chip select works independently. The same bank and row on two chip selects with different policies behave as in R2 and R3 respectively.
- R5: After a row conflict the bank holds the newly requested row: the new row then hits and the old row conflicts.
- R6: An access to an open-page bank restarts its idle count at zero. Once it has been idle for `cfg_idle_limit` cycles, `pre_req_valid` pulses for one cycle with `pre_cs`/`pre_bank` naming it, and the bank is closed afterwards. A new access before that point restarts the count.
- R7: While `ref_req` is high and any bank is open, `pre_all` is high, `ref_grant` is low and `pre_req_valid` is low. One cycle later every bank is closed, `pre_all` falls and `ref_grant` rises. With no bank open, `ref_grant` follows `ref_req` in the same cycle.
- R8: Each bank holds at most one open row, and an access to one bank leaves the records of the other banks unchanged.
- R9: When several banks are past their idle limit at the same time, they are served one per cycle, lowest flat index (cs*NUM_BANKS + bank) first.
- R10: Every `cmd_col` bit other than bit 10 equals the corresponding `req_col` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all banks closed |
| cfg_closed_page | input | NUM_CS | Per-chip-select policy, 1 = closed page |
| cfg_idle_limit | input | IDLE_W | Idle cycles before an open page is closed |
| req_valid | input | 1 | Request present this cycle |
| req_cs | input | CS_W | Request chip select |
| req_bank | input | BANK_W | Request logical bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column address |
| ref_req | input | 1 | Refresh wanted |
| dec_valid | output | 1 | Decision valid |
| dec_class | output | 2 | Command class: 00 hit, 01 activate, 10 conflict |
| cmd_col | output | COL_W | Column address with auto-precharge bit 10 applied |
| pre_req_valid | output | 1 | Single-bank precharge request on idle timeout |
| pre_cs | output | CS_W | Chip select to precharge |
| pre_bank | output | BANK_W | Bank to precharge |
| pre_all | output | 1 | Precharge-all request ahead of refresh |
| ref_grant | output | 1 | Refresh may proceed; no page open |

## Verification
The assertions assume that no request is presented while `ref_req` is high, and that `cfg_idle_limit` changes only between deliberate phases, so that a bank past its limit stays pending until it is served. The directed tasks keep `req_valid` low across each refresh window. They change the idle limit only on a falling edge at the start of a phase, with the affected banks already open, and they reset the block between scenarios so that no stale open row carries over into the next one.

// File: rtl/page_tracker_pkg.sv
package page_tracker_pkg;
   typedef enum logic [1:0] {
      CLS_HIT      = 2'b00,
      CLS_ACTIVATE = 2'b01,
      CLS_CONFLICT = 2'b10
   } cmd_class_e;

   localparam int AP_BIT = 10;
endpackage

// File: rtl/pt_bank_entry.sv
module pt_bank_entry #(
   parameter int ROW_W  = 14,
   parameter int IDLE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access,
   input  logic              closed_mode,
   input  logic [ROW_W-1:0]  new_row,
   input  logic              close_now,
   input  logic [IDLE_W-1:0] idle_limit,
   output logic              is_open,
   output logic [ROW_W-1:0]  row_q,
   output logic              expired
);
   logic              open_q;
   logic [IDLE_W-1:0] idle_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         row_q    <= '0;
         idle_cnt <= '0;
      end else if (access) begin
         open_q   <= !closed_mode;
         row_q    <= new_row;
         idle_cnt <= '0;
      end else if (close_now) begin
         open_q   <= 1'b0;
         idle_cnt <= '0;
      end else if (open_q && idle_cnt < idle_limit) begin
         idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign is_open = open_q;
   assign expired = open_q && (idle_cnt >= idle_limit);

   // R2
   closed_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access && closed_mode |=> !open_q);
   // R3
   open_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access && !closed_mode |=> open_q && row_q == $past(new_row));
   // R6
   close_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      close_now && !access |=> !open_q);
   // R6
   expiry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expired && !access && !close_now && $stable(idle_limit) |=> expired || $changed(idle_limit));
endmodule

// File: rtl/pt_pick.sv
module pt_pick #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     cand,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/page_tracker.sv
module page_tracker
   import page_tracker_pkg::*;
#(
   parameter int NUM_CS    = 2,
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 14,
   parameter int COL_W     = 12,
   parameter int IDLE_W    = 8,
   localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ENTRIES = NUM_CS * NUM_BANKS,
   localparam int IDX_W   = CS_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CS-1:0] cfg_closed_page,
   input  logic [IDLE_W-1:0] cfg_idle_limit,
   input  logic              req_valid,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              ref_req,
   output logic              dec_valid,
   output logic [1:0]        dec_class,
   output logic [COL_W-1:0]  cmd_col,
   output logic              pre_req_valid,
   output logic [CS_W-1:0]   pre_cs,
   output logic [BANK_W-1:0] pre_bank,
   output logic              pre_all,
   output logic              ref_grant
);
   initial begin
      cs_pow2_chk: assert (NUM_CS >= 2 && (1 << CS_W) == NUM_CS);
      bank_pow2_chk: assert (NUM_BANKS >= 2 && (1 << BANK_W) == NUM_BANKS);
      col_width_chk: assert (COL_W > AP_BIT);
   end

   logic [IDX_W-1:0]   req_idx;
   logic [ENTRIES-1:0] access_vec, open_vec, expired_vec, close_vec, cand_vec;
   logic [ROW_W-1:0]   rows [ENTRIES];
   logic               pick_found;
   logic [IDX_W-1:0]   pick_idx;
   logic               any_open;
   logic               sel_closed;

   assign req_idx = {req_cs, req_bank};

   for (genvar g = 0; g < ENTRIES; g++) begin : g_bank
      assign access_vec[g] = req_valid && (req_idx == IDX_W'(g));
      assign close_vec[g]  = (ref_req && !access_vec[g]) ||
                             (pick_found && pick_idx == IDX_W'(g));
      pt_bank_entry #(.ROW_W(ROW_W), .IDLE_W(IDLE_W)) u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .access     (access_vec[g]),
         .closed_mode(cfg_closed_page[g / NUM_BANKS]),
         .new_row    (req_row),
         .close_now  (close_vec[g]),
         .idle_limit (cfg_idle_limit),
         .is_open    (open_vec[g]),
         .row_q      (rows[g]),
         .expired    (expired_vec[g])
      );
   end

   assign any_open = |open_vec;
   assign cand_vec = ref_req ? '0 : (expired_vec & ~access_vec);

   pt_pick #(.N(ENTRIES)) u_pick (
      .cand (cand_vec),
      .found(pick_found),
      .idx  (pick_idx)
   );

   assign sel_closed = cfg_closed_page[req_cs];

   always_comb begin
      cmd_class_e cls;
      if (!open_vec[req_idx])              cls = CLS_ACTIVATE;
      else if (rows[req_idx] == req_row)   cls = CLS_HIT;
      else                                 cls = CLS_CONFLICT;
      dec_class       = cls;
      cmd_col         = req_col;
      cmd_col[AP_BIT] = sel_closed;
   end

   assign dec_valid     = req_valid;
   assign pre_req_valid = pick_found;
   assign pre_cs        = pick_idx[IDX_W-1:BANK_W];
   assign pre_bank      = pick_idx[BANK_W-1:0];
   assign pre_all       = ref_req && any_open;
   assign ref_grant     = ref_req && !any_open;

   // R7
   pre_all_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req && !req_valid |=> !pre_all);
   // R7
   no_req_in_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> !req_valid);
   // R9
   no_repeat_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_req_valid |=> !pre_req_valid || !(pre_cs == $past(pre_cs) && pre_bank == $past(pre_bank)));
   // R1
   closed_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !ref_req |=> !(req_valid && dec_class == 2'b00 &&
         req_cs == $past(req_cs) && req_bank == $past(req_bank) && $past(sel_closed) &&
         $stable(cfg_closed_page)));
endmodule

// File: tb/page_tracker_test.sv
module page_tracker_test;
   localparam int NUM_CS = 2, NUM_BANKS = 4, ROW_W = 14, COL_W = 12, IDLE_W = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        cfg_closed_page;
   logic [IDLE_W-1:0] cfg_idle_limit;
   logic              req_valid;
   logic [0:0]        req_cs;
   logic [1:0]        req_bank;
   logic [ROW_W-1:0]  req_row;
   logic [COL_W-1:0]  req_col;
   logic              ref_req;
   logic              dec_valid;
   logic [1:0]        dec_class;
   logic [COL_W-1:0]  cmd_col;
   logic              pre_req_valid;
   logic [0:0]        pre_cs;
   logic [1:0]        pre_bank;
   logic              pre_all;
   logic              ref_grant;

   int checks = 0;
   int errors = 0;

   localparam logic [1:0] HIT = 2'b00, ACT = 2'b01, CONF = 2'b10;

   always #4 clk = ~clk;

   page_tracker #(.NUM_CS(NUM_CS), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
                  .COL_W(COL_W), .IDLE_W(IDLE_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_closed_page(cfg_closed_page),
      .cfg_idle_limit(cfg_idle_limit), .req_valid(req_valid), .req_cs(req_cs),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .ref_req(ref_req),
      .dec_valid(dec_valid), .dec_class(dec_class), .cmd_col(cmd_col),
      .pre_req_valid(pre_req_valid), .pre_cs(pre_cs), .pre_bank(pre_bank),
      .pre_all(pre_all), .ref_grant(ref_grant));

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(logic [1:0] closed, int limit);
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; ref_req = 1'b0;
      req_cs = '0; req_bank = '0; req_row = '0; req_col = '0;
      cfg_closed_page = closed; cfg_idle_limit = IDLE_W'(limit);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Presents one request; returns the decision seen before the committing edge.
   task automatic issue(int cs, int bank, int row, int col,
                        output logic [1:0] cls, output logic [COL_W-1:0] colo);
      @(negedge clk);
      req_valid = 1'b1; req_cs = 1'(cs); req_bank = 2'(bank);
      req_row = ROW_W'(row); req_col = COL_W'(col);
      #1;
      cls = dec_class; colo = cmd_col;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b00, 200);
      #1;
      check("R7 reset pre_all", pre_all, 0);
      check("R6 reset pre_req_valid", pre_req_valid, 0);
      check("R7 reset ref_grant", ref_grant, 0);
      issue(0, 0, 3, 0, c, o);
      check("R1 first access activate", c, ACT);
   endtask

   task automatic t_open_hit();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b00, 200);
      issue(1, 2, 40, 12'h123, c, o);
      check("R3 open first activate", c, ACT);
      check("R3 open bit10 clear", o[10], 0);
      issue(1, 2, 40, 12'h123, c, o);
      check("R3 repeat row hit", c, HIT);
      check("R1 dec_valid", dec_valid, 0);
   endtask

   task automatic t_closed();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b11, 200);
      issue(0, 1, 7, 0, c, o);
      check("R2 closed activate", c, ACT);
      check("R2 closed bit10 set", o[10], 1);
      issue(0, 1, 7, 0, c, o);
      check("R2 closed repeat activate", c, ACT);
   endtask

   task automatic t_per_cs();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b10, 200);
      issue(0, 2, 5, 0, c, o);
      check("R4 cs0 open bit10", o[10], 0);
      issue(1, 2, 5, 0, c, o);
      check("R4 cs1 closed bit10", o[10], 1);
      issue(0, 2, 5, 0, c, o);
      check("R4 cs0 hit", c, HIT);
      issue(1, 2, 5, 0, c, o);
      check("R4 cs1 activate", c, ACT);
   endtask

   task automatic t_conflict();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b00, 200);
      issue(1, 3, 3, 0, c, o);
      issue(1, 3, 7, 0, c, o);
      check("R1 conflict", c, CONF);
      issue(1, 3, 7, 0, c, o);
      check("R5 new row hit", c, HIT);
      issue(1, 3, 3, 0, c, o);
      check("R5 old row conflict", c, CONF);
   endtask

   task automatic t_banks();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b00, 200);
      issue(0, 0, 1, 0, c, o);
      issue(0, 1, 9, 0, c, o);
      check("R8 other bank activate", c, ACT);
      issue(0, 0, 1, 0, c, o);
      check("R8 first bank still hit", c, HIT);
   endtask

   task automatic t_col();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b10, 200);
      issue(0, 0, 0, 12'hFFF, c, o);
      check("R10 open col passthrough", o, 12'hBFF);
      issue(1, 0, 0, 12'h000, c, o);
      check("R10 closed col passthrough", o, 12'h400);
   endtask

   task automatic t_idle();
      logic [1:0] c; logic [COL_W-1:0] o;
      int n;
      do_reset(2'b00, 5);
      issue(1, 1, 12, 0, c, o);
      n = 0;
      #1;
      while (!pre_req_valid && n < 50) begin
         @(negedge clk); #1; n++;
      end
      check("R6 idle cycles to pre_req", n, 5);
      check("R6 pre_cs", pre_cs, 1);
      check("R6 pre_bank", pre_bank, 1);
      @(negedge clk); #1;
      check("R6 pre_req one cycle", pre_req_valid, 0);
      issue(1, 1, 12, 0, c, o);
      check("R6 closed after timeout", c, ACT);
      repeat (3) @(negedge clk);
      issue(1, 1, 12, 0, c, o);
      check("R6 access before limit hits", c, HIT);
      n = 0;
      #1;
      while (!pre_req_valid && n < 50) begin
         @(negedge clk); #1; n++;
      end
      check("R6 count restarted", n, 5);
   endtask

   task automatic t_multi_idle();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b00, 200);
      issue(1, 2, 4, 0, c, o);
      issue(0, 1, 4, 0, c, o);
      @(negedge clk);
      cfg_idle_limit = 8'd1;
      #1;
      check("R9 first pre_req", pre_req_valid, 1);
      check("R9 lowest first cs", pre_cs, 0);
      check("R9 lowest first bank", pre_bank, 1);
      @(negedge clk); #1;
      check("R9 second pre_req", pre_req_valid, 1);
      check("R9 second cs", pre_cs, 1);
      check("R9 second bank", pre_bank, 2);
      @(negedge clk); #1;
      check("R9 none left", pre_req_valid, 0);
   endtask

   task automatic t_refresh();
      logic [1:0] c; logic [COL_W-1:0] o;
      do_reset(2'b00, 200);
      issue(0, 0, 2, 0, c, o);
      issue(1, 3, 6, 0, c, o);
      @(negedge clk);
      ref_req = 1'b1;
      cfg_idle_limit = 8'd0;
      #1;
      check("R7 pre_all raised", pre_all, 1);
      check("R7 no grant yet", ref_grant, 0);
      check("R7 pre_req suppressed", pre_req_valid, 0);
      @(negedge clk); #1;
      check("R7 pre_all dropped", pre_all, 0);
      check("R7 grant", ref_grant, 1);
      @(negedge clk);
      ref_req = 1'b0;
      cfg_idle_limit = 8'd200;
      issue(0, 0, 2, 0, c, o);
      check("R7 bank closed by refresh", c, ACT);
      issue(1, 3, 6, 0, c, o);
      check("R7 cs1 bank closed by refresh", c, ACT);
      do_reset(2'b00, 200);
      @(negedge clk);
      ref_req = 1'b1;
      #1;
      check("R7 immediate grant", ref_grant, 1);
      @(negedge clk);
      ref_req = 1'b0;
   endtask

   initial begin
      fork
         begin
            t_reset_state();
            t_open_hit();
            t_closed();
            t_per_cs();
            t_conflict();
            t_banks();
            t_col();
            t_idle();
            t_multi_idle();
            t_refresh();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule